// File: doc/BRIEF.md
# Parallel-bit packet dispatcher

This block takes a wide fetch word holding a fixed number of 32-bit operation slots and hands those operations to a row of fixed-function execution lanes. Each slot has a chaining flag. A set flag means the next slot goes out in the same cycle. A clear flag ends the current execute group, so the next slot waits for a later cycle. Several groups can therefore share one fetch word without any no-operation padding. The word is drained over as many cycles as it has groups.

Each slot names its own target lane, and the block routes it there. The dispatcher does not look at operand dependencies and inserts no stalls between groups. It trusts the packing to be safe. It takes a new word with a valid/ready handshake. Ready is raised while the block is empty and in the cycle that sends the last group of the current word, so words can follow each other with no bubble. If two slots in one group name the same lane, the earlier slot wins, the later slot is discarded and a sticky error flag is set.

Top module: `pbit_dispatch`

## Requirements
- R1: A synchronous active-high reset empties the held word and clears every lane valid bit and the error flag. After reset `in_ready` is 1.
- R2: Within each 32-bit slot, bit 0 is the chaining flag and bits [3:1] are the target lane index. The whole 32-bit slot appears unchanged on `lane_op[l*32 +: 32]` of its target lane `l`. Slot `j` occupies `in_word[j*32 +: 32]`.
- R3: Slots are scanned from slot 0 upward. A set chaining flag on slot i puts slot i+1 in the same group. A clear flag starts a new group with slot i+1 in the following cycle.
- R4: The chaining flag of the highest slot is ignored, and a group never takes slots from the next fetch word.
- R5: One group is issued per cycle. A word accepted at clock edge k shows its group g on the lane outputs after edge k+1+g, so a word with n groups keeps the lanes busy for n consecutive cycles.
- R6: `in_ready` is 1 when no word is held, and in the cycle that computes the final group of the held word. It is 0 otherwise. A word offered in that cycle is taken with no gap between words.
- R7: A lane that receives no slot from the current group has its valid bit at 0. When no word is held, all lane valid bits are 0 one cycle later.
- R8: When two slots of one group name the same lane, only the lower-numbered slot is issued. `grp_error` goes to 1 with that group's outputs and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetch word offered |
| in_word | input | 256 | Fetch word, 8 slots of 32 bits each |
| in_ready | output | 1 | Block takes the offered word at the next edge |
| lane_valid | output | 8 | Per-lane issue valid |
| lane_op | output | 256 | Per-lane operation payload, lane l at [l*32 +: 32] |
| grp_error | output | 1 | Sticky flag for a lane conflict within one group |

## Verification
A word is taken at the edge where `in_valid` and `in_ready` are both high. Its first group is registered one edge later, and each following group one edge after the one before. The error flag rises on the same edge as the group that caused it. `in_ready` is a function of the held state in the current cycle. The bench therefore steps a reference model exactly once per clock. At each falling edge it compares the lane outputs and the error flag with the expectations the model produced one cycle earlier. It checks `in_ready` against the model's current state before it decides whether that edge takes a word.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  // field positions inside one operation slot
  localparam int CHAIN_POS = 0;  // chaining flag
  localparam int LANE_POS  = 1;  // lowest bit of the target lane index
endpackage

// File: rtl/pbd_group_scan.sv
module pbd_group_scan #(
  parameter int SLOTS = 8,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic             active,
  input  logic [SLOTS-1:0] chain,
  input  logic [PTR_W-1:0] start,
  output logic [SLOTS-1:0] member,
  output logic             final_grp,
  output logic [PTR_W-1:0] next_start
);
  logic [PTR_W:0] count;

  // a slot belongs to the group if it is the start slot or is chained from
  // a member directly below it
  always_comb begin
    logic carry;
    logic m;
    carry = 1'b0;
    for (int j = 0; j < SLOTS; j++) begin
      m = active && ((start == PTR_W'(j)) || carry);
      member[j] = m;
      carry = m && chain[j];
    end
  end

  always_comb begin
    count = '0;
    for (int j = 0; j < SLOTS; j++) count = count + (PTR_W+1)'(member[j]);
  end

  assign final_grp  = member[SLOTS-1];
  assign next_start = PTR_W'({1'b0, start} + count);
endmodule

// File: rtl/pbd_lane_route.sv
module pbd_lane_route
  import pbd_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 32,
  parameter int LANES  = 8,
  localparam int LANE_IW = $clog2(LANES)
) (
  input  logic [SLOTS*SLOT_W-1:0] slots,
  input  logic [SLOTS-1:0]        member,
  output logic [LANES-1:0]        lane_hit,
  output logic [LANES*SLOT_W-1:0] lane_data,
  output logic                    clash
);
  logic [LANE_IW-1:0] tgt [SLOTS];

  for (genvar j = 0; j < SLOTS; j++) begin : g_tgt
    assign tgt[j] = slots[j*SLOT_W + LANE_POS +: LANE_IW];
  end

  // per lane: the lowest-numbered member aimed at it wins
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              hit;
    logic [SLOT_W-1:0] dat;
    always_comb begin
      hit = 1'b0;
      dat = '0;
      for (int j = SLOTS-1; j >= 0; j--) begin
        if (member[j] && (tgt[j] == LANE_IW'(l))) begin
          hit = 1'b1;
          dat = slots[j*SLOT_W +: SLOT_W];
        end
      end
    end
    assign lane_hit[l] = hit;
    assign lane_data[l*SLOT_W +: SLOT_W] = dat;
  end

  always_comb begin
    clash = 1'b0;
    for (int j = 1; j < SLOTS; j++)
      for (int k = 0; k < j; k++)
        if (member[j] && member[k] && (tgt[j] == tgt[k])) clash = 1'b1;
  end

  // R7: without a clash every member lands on exactly one lane and no other lane fires
  always_comb begin
    if (!clash) begin
      hit_match_chk: assert ($countones(lane_hit) == $countones(member));
    end
  end
endmodule

// File: rtl/pbit_dispatch.sv
module pbit_dispatch
  import pbd_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 32,
  parameter int LANES  = 8,
  localparam int PTR_W  = $clog2(SLOTS),
  localparam int WORD_W = SLOTS*SLOT_W,
  localparam int OUT_W  = LANES*SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic [LANES-1:0]  lane_valid,
  output logic [OUT_W-1:0]  lane_op,
  output logic              grp_error
);
  logic [WORD_W-1:0] word_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              busy_q;

  logic [SLOTS-1:0]  chain;
  logic [SLOTS-1:0]  member;
  logic              final_grp;
  logic [PTR_W-1:0]  next_ptr;
  logic [LANES-1:0]  lane_hit;
  logic [OUT_W-1:0]  lane_data;
  logic              clash;
  logic              take;

  for (genvar j = 0; j < SLOTS; j++) begin : g_chain
    assign chain[j] = word_q[j*SLOT_W + CHAIN_POS];
  end

  pbd_group_scan #(.SLOTS(SLOTS)) u_scan (
    .active     (busy_q),
    .chain      (chain),
    .start      (ptr_q),
    .member     (member),
    .final_grp  (final_grp),
    .next_start (next_ptr)
  );

  pbd_lane_route #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .LANES(LANES)) u_route (
    .slots     (word_q),
    .member    (member),
    .lane_hit  (lane_hit),
    .lane_data (lane_data),
    .clash     (clash)
  );

  assign in_ready = !busy_q || final_grp;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      ptr_q      <= '0;
      busy_q     <= 1'b0;
      lane_valid <= '0;
      lane_op    <= '0;
      grp_error  <= 1'b0;
    end else begin
      lane_valid <= lane_hit;
      lane_op    <= lane_data;
      if (clash) grp_error <= 1'b1;
      if (busy_q) begin
        ptr_q <= next_ptr;
        if (final_grp) busy_q <= 1'b0;
      end
      if (take) begin
        word_q <= in_word;
        ptr_q  <= '0;
        busy_q <= 1'b1;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (lane_valid == '0 && !grp_error && in_ready));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy_q |=> (lane_valid == '0));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) grp_error |=> grp_error);

  // R6
  hold_word_chk: assert property (@(posedge clk) disable iff (rst) (busy_q && !in_ready) |=> busy_q);

  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst) take |=> (busy_q && ptr_q == '0));

  // R5
  ptr_adv_chk: assert property (@(posedge clk) disable iff (rst) (busy_q && !final_grp) |=> (ptr_q > $past(ptr_q)));
endmodule

// File: tb/pbit_dispatch_test.sv
module pbit_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = 32;
  localparam int LANES  = 8;
  localparam int WORD_W = SLOTS*SLOT_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [WORD_W-1:0] in_word = '0;
  logic              in_ready;
  logic [LANES-1:0]  lane_valid;
  logic [LANES*SLOT_W-1:0] lane_op;
  logic              grp_error;

  pbit_dispatch #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .LANES(LANES)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .lane_valid(lane_valid), .lane_op(lane_op),
    .grp_error(grp_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic              m_busy = 1'b0;
  logic [WORD_W-1:0] m_word = '0;
  int                m_ptr = 0;
  string             m_tag = "R3";
  logic [LANES-1:0]  exp_valid = '0;
  logic [SLOT_W-1:0] exp_op [LANES];
  logic              exp_err = 1'b0;
  string             exp_tag = "R7";
  logic              last_acc = 1'b0;
  bit                gaps = 1'b0;
  string             in_tag = "R3";

  logic [WORD_W-1:0] wq [$];
  string             tq [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int grp_end(input logic [WORD_W-1:0] w, input int p);
    int e = p;
    while (e < SLOTS-1 && w[e*SLOT_W]) e++;
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] mkword(input logic [SLOTS-1:0] par,
                                               input logic [SLOTS*3-1:0] lanes);
    logic [WORD_W-1:0] w;
    for (int j = 0; j < SLOTS; j++)
      w[j*SLOT_W +: SLOT_W] = {$urandom() & 32'hFFFF_FFF0} | {28'd0, lanes[j*3 +: 3], par[j]};
    return w;
  endfunction

  task automatic push(input logic [WORD_W-1:0] w, input string tag);
    wq.push_back(w);
    tq.push_back(tag);
  endtask

  task automatic step();
    logic exp_rdy;
    logic acc;
    logic dup;
    @(negedge clk);
    chk(lane_valid == exp_valid, exp_tag, "lane_valid", 32'(lane_valid), 32'(exp_valid));
    for (int l = 0; l < LANES; l++)
      if (exp_valid[l])
        chk(lane_op[l*SLOT_W +: SLOT_W] == exp_op[l], "R2", "lane_op",
            lane_op[l*SLOT_W +: SLOT_W], exp_op[l]);
    chk(grp_error == exp_err, "R8", "grp_error", 32'(grp_error), 32'(exp_err));
    if (last_acc) in_valid = 1'b0;
    if (!in_valid && wq.size() > 0 && (!gaps || $urandom_range(3) != 0)) begin
      in_valid = 1'b1;
      in_word  = wq.pop_front();
      in_tag   = tq.pop_front();
    end
    exp_rdy = !m_busy || (grp_end(m_word, m_ptr) == SLOTS-1);
    chk(in_ready == exp_rdy, "R6", "in_ready", 32'(in_ready), 32'(exp_rdy));
    acc = in_valid && exp_rdy;
    last_acc = acc;
    exp_valid = '0;
    dup = 1'b0;
    if (m_busy) begin
      int e = grp_end(m_word, m_ptr);
      for (int j = m_ptr; j <= e; j++) begin
        int l = int'(m_word[j*SLOT_W + 1 +: 3]);
        if (exp_valid[l]) dup = 1'b1;
        else begin
          exp_valid[l] = 1'b1;
          exp_op[l] = m_word[j*SLOT_W +: SLOT_W];
        end
      end
      exp_tag = m_tag;
      m_ptr = e + 1;
      if (e == SLOTS-1) m_busy = 1'b0;
    end else begin
      exp_tag = "R7";
    end
    if (dup) exp_err = 1'b1;
    if (acc) begin
      m_word = in_word;
      m_ptr  = 0;
      m_busy = 1'b1;
      m_tag  = in_tag;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(lane_valid == '0, "R1", "lane_valid after reset", 32'(lane_valid), 32'd0);
    chk(grp_error == 1'b0, "R1", "grp_error after reset", 32'(grp_error), 32'd0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    m_busy = 1'b0;
    exp_valid = '0;
    exp_err = 1'b0;
    exp_tag = "R7";
    last_acc = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0425));
    for (int l = 0; l < LANES; l++) exp_op[l] = '0;
    repeat (3) @(posedge clk);
    do_reset();
    repeat (3) step();                                     // R7 idle
    // R5: every slot its own group, 8 cycles
    push(mkword(8'h00, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}), "R5");
    // R4: all flags set incl. last slot, one group, then next word starts fresh
    push(mkword(8'hFF, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}), "R4");
    push(mkword(8'h80, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}), "R4");
    // R3: pairs chained, back to back with previous words
    push(mkword(8'h55, {3'd1,3'd0,3'd3,3'd2,3'd5,3'd4,3'd7,3'd6}), "R3");
    repeat (24) step();
    // R8: lane 1 named twice in one group
    push(mkword(8'hFF, {3'd7,3'd6,3'd5,3'd4,3'd1,3'd2,3'd1,3'd0}), "R8");
    repeat (6) step();
    chk(grp_error == 1'b1, "R8", "sticky flag set", 32'(grp_error), 32'd1);
    // random words with random offering gaps
    gaps = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [SLOTS-1:0] par = SLOTS'($urandom());
      logic [SLOTS*3-1:0] ln = (SLOTS*3)'($urandom());
      push(mkword(par, ln), "R3");
    end
    while (wq.size() > 0 || in_valid || m_busy) step();
    repeat (3) step();
    do_reset();                                             // R1 clears sticky flag
    gaps = 1'b0;
    push(mkword(8'h0F, {3'd2,3'd3,3'd4,3'd5,3'd6,3'd7,3'd0,3'd1}), "R3");
    repeat (10) step();
    finish_run();
  end
endmodule